// File: doc/BRIEF.md
# Command-Driven I2C Bus Master Sequencer

This block is an I2C bus master that software steers through a handful of plain register-style strobes instead of toggling pins itself. A 4-bit command code is written and the block carries out the matching bus primitive on open-drain SCL and SDA. The primitives are START, shifting out a byte, sampling the acknowledge bit, shifting in a byte, driving an acknowledge bit, and STOP. Several composite codes chain two or three primitives and run them back to back as a single command.

A transmit byte register feeds every send step, and a receive byte register holds the result of every receive step. A received-acknowledge status bit records the level seen in the last acknowledge-sampling slot. A busy flag covers the stretch from START to STOP, and a sticky completion flag is raised at the end of each command. When auto-send is enabled, writing the transmit register is enough on its own to start a send-then-sample-acknowledge sequence.

The bus is driven only through output enables: a 1 on an enable pulls the line low, and a 0 lets it float high. Every bit period is cut into four equal quarters, each `QTR_CYCLES` clocks long. The SDA input passes through a synchronizer before it is sampled.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both output enables are 0 (lines released), and busy, the completion flag, the receive byte and the received-acknowledge bit are all 0.
- R2: Code 0001 (START) makes SDA fall while SCL is high, then pulls SCL low. It sets busy to 1 and raises the completion flag when it ends.
- R3: Code 0010 shifts out the transmit register most significant bit first, one bit per SCL pulse. While SCL is high, SDA changes only during START and STOP.
- R4: Code 0011 releases SDA for one SCL pulse and copies the SDA level sampled while SCL is high into the received-acknowledge bit (0 = acknowledged, 1 = not acknowledged).
- R5: Code 0100 releases SDA for eight SCL pulses and stores the sampled bits, first bit as the most significant, in the receive byte register.
- R6: Code 0101 drives the level of the ack-out input onto SDA for one SCL pulse.
- R7: Code 0110 (STOP) makes SDA rise while SCL is high, leaves both lines released, and clears busy.
- R8: Code 1001 performs START, then a send of the transmit byte, then an acknowledge sample, in that order, and raises the completion flag once at the end.
- R9: Code 1010 performs a send of the transmit byte followed by an acknowledge sample.
- R10: Code 1011 receives a byte and then drives 0 in the acknowledge slot. Code 1100 receives a byte and then drives 1. In both cases the ack-out input is ignored.
- R11: Every other code, including the reserved codes 0111 and 1000, produces no SCL pulse and no change on either enable, and raises the completion flag within a few clocks.
- R12: While auto-send is 1, a write to the transmit register that arrives while no command is running performs the 1010 sequence. While auto-send is 0, such a write starts nothing.
- R13: A command write that arrives while a command is executing is ignored. It causes no bus activity and no extra completion.
- R14: Once the completion flag is set, it stays at 1 until the clear strobe is pulsed. A new completion in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | One-cycle strobe that writes cmdCode |
| cmdCode | input | 4 | Command code |
| txWr | input | 1 | One-cycle strobe that writes txData into the transmit register |
| txData | input | 8 | Transmit byte |
| autoTx | input | 1 | Auto-send enable |
| ackOut | input | 1 | Level driven by code 0101 |
| irqClr | input | 1 | Clears the completion flag |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| rxData | output | 8 | Last received byte |
| ackIn | output | 1 | Last sampled acknowledge level |
| busy | output | 1 | High from START to the end of STOP |
| irqFlag | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the strobes are synchronous one-cycle pulses and that any other device on SDA changes the line only while SCL is low. The bench's slave model keeps to that rule by updating its drive only on SCL falling edges. The assertions also assume that `QTR_CYCLES` is large enough for the synchronizer delay to fall inside the SCL-high window. The bench runs with four clocks per quarter and never issues STOP while its slave could still be driving SDA. It keeps its slave in read mode only for receive codes and for the acknowledge drive that follows them.

// File: rtl/i2c_cmd_pkg.sv
`timescale 1ns/1ps
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    P_NONE, P_START, P_SEND, P_ACKIN, P_RECV, P_ACKOUT, P_STOP
  } prim_e;

  localparam logic [3:0] CMD_START  = 4'b0001;
  localparam logic [3:0] CMD_SEND   = 4'b0010;
  localparam logic [3:0] CMD_ACKIN  = 4'b0011;
  localparam logic [3:0] CMD_RECV   = 4'b0100;
  localparam logic [3:0] CMD_ACKOUT = 4'b0101;
  localparam logic [3:0] CMD_STOP   = 4'b0110;
  localparam logic [3:0] CMD_STXACK = 4'b1001;
  localparam logic [3:0] CMD_TXACK  = 4'b1010;
  localparam logic [3:0] CMD_RXACK  = 4'b1011;
  localparam logic [3:0] CMD_RXNAK  = 4'b1100;

  localparam int MAX_STEPS = 3;

  // strobes from control to the bit engine
  typedef struct packed {
    logic  go;
    prim_e prim;
    logic  ackBit;
  } step_ctl_t;

  // decoded command: ordered primitive list
  typedef struct packed {
    logic                    valid;
    prim_e [MAX_STEPS-1:0]   steps;
    logic [1:0]              lastIdx;
    logic                    forceAck;
    logic                    forceVal;
  } plan_t;

  function automatic plan_t decodeCmd(input logic [3:0] code);
    plan_t p;
    p = '0;
    p.valid = 1'b1;
    case (code)
      CMD_START:  p.steps[0] = P_START;
      CMD_SEND:   p.steps[0] = P_SEND;
      CMD_ACKIN:  p.steps[0] = P_ACKIN;
      CMD_RECV:   p.steps[0] = P_RECV;
      CMD_ACKOUT: p.steps[0] = P_ACKOUT;
      CMD_STOP:   p.steps[0] = P_STOP;
      CMD_STXACK: begin
        p.steps[0] = P_START; p.steps[1] = P_SEND; p.steps[2] = P_ACKIN;
        p.lastIdx = 2'd2;
      end
      CMD_TXACK: begin
        p.steps[0] = P_SEND; p.steps[1] = P_ACKIN; p.lastIdx = 2'd1;
      end
      CMD_RXACK, CMD_RXNAK: begin
        p.steps[0] = P_RECV; p.steps[1] = P_ACKOUT; p.lastIdx = 2'd1;
        p.forceAck = 1'b1;
        p.forceVal = (code == CMD_RXNAK);
      end
      default: p.valid = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/i2c_cmd_ctrl.sv
`timescale 1ns/1ps
module i2c_cmd_ctrl import i2c_cmd_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWr,
  input  logic [3:0] cmdCode,
  input  logic      txWr,
  input  logic      autoTx,
  input  logic      ackOut,
  input  logic      irqClr,
  input  logic      primDone,
  output step_ctl_t ctl,
  output logic      busy,
  output logic      irqFlag
);

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} cstate_e;

  cstate_e    st;
  plan_t      plan;
  plan_t      req;
  logic [1:0] idx;
  logic [3:0] launchCode;
  logic       accept;
  prim_e      curPrim;
  logic       stepFinished;
  logic       cmdComplete;

  always_comb begin
    launchCode = cmdWr ? cmdCode : CMD_TXACK;
    req        = decodeCmd(launchCode);
    accept     = (cmdWr || (txWr && autoTx)) && (st == C_IDLE);
  end

  always_comb begin
    curPrim      = plan.steps[idx];
    stepFinished = (st == C_WAIT) && primDone;
    cmdComplete  = (accept && !req.valid) || (stepFinished && (idx == plan.lastIdx));
    ctl.go       = (st == C_ISSUE);
    ctl.prim     = curPrim;
    ctl.ackBit   = plan.forceAck ? plan.forceVal : ackOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= C_IDLE;
      plan    <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      case (st)
        C_IDLE: begin
          if (accept && req.valid) begin
            plan <= req;
            idx  <= '0;
            st   <= C_ISSUE;
          end
        end
        C_ISSUE: st <= C_WAIT;
        C_WAIT: begin
          if (primDone) begin
            if (idx == plan.lastIdx) begin
              st <= C_IDLE;
            end else begin
              idx <= idx + 2'd1;
              st  <= C_ISSUE;
            end
          end
        end
        default: st <= C_IDLE;
      endcase

      if (ctl.go && (curPrim == P_START)) busy <= 1'b1;
      else if (stepFinished && (curPrim == P_STOP)) busy <= 1'b0;

      if (cmdComplete) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
    end
  end

  // R14
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !irqClr |=> irqFlag);

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(primDone));

  // R13
  plan_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == C_WAIT) && !primDone |=> $stable(plan) && $stable(idx));

endmodule

// File: rtl/i2c_cmd_dp.sv
`timescale 1ns/1ps
module i2c_cmd_dp import i2c_cmd_pkg::*; #(
  parameter int QTR_CYCLES  = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  step_ctl_t  ctl,
  input  logic       txWr,
  input  logic [7:0] txData,
  input  logic       sdaIn,
  output logic       primDone,
  output logic [7:0] rxData,
  output logic       ackIn,
  output logic       sclOe,
  output logic       sdaOe
);

  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(QTR_CYCLES - 1);

  logic                   active;
  prim_e                  primR;
  logic                   ackBitR;
  logic [1:0]             q;
  logic [CW-1:0]          divCnt;
  logic [2:0]             bitCnt;
  logic [7:0]             txReg;
  logic [7:0]             shReg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sdaS;
  logic                   qEnd, lastQ, sampleNow, multiBit, primEnd;
  logic                   sclNext, sdaNext;

  // input synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= sdaIn;
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
    end
  endgenerate
  assign sdaS = syncQ[SYNC_STAGES-1];

  always_comb begin
    qEnd      = (divCnt == DIV_LAST);
    lastQ     = qEnd && (q == 2'd3);
    sampleNow = active && qEnd && (q == 2'd2);
    multiBit  = (primR == P_SEND) || (primR == P_RECV);
    primEnd   = active && lastQ && (!multiBit || (bitCnt == 3'd0));
  end

  // line drive per primitive and quarter
  always_comb begin
    sclNext = sclOe;
    sdaNext = sdaOe;
    case (primR)
      P_START: begin
        sdaNext = (q >= 2'd2);
        sclNext = (q == 2'd0) ? sclOe : (q == 2'd3);
      end
      P_STOP: begin
        sclNext = (q == 2'd0);
        sdaNext = (q <= 2'd1);
      end
      P_SEND: begin
        sclNext = (q == 2'd0) || (q == 2'd3);
        sdaNext = !shReg[7];
      end
      P_ACKOUT: begin
        sclNext = (q == 2'd0) || (q == 2'd3);
        sdaNext = !ackBitR;
      end
      P_ACKIN, P_RECV: begin
        sclNext = (q == 2'd0) || (q == 2'd3);
        sdaNext = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (txWr) begin
      txReg <= txData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      primR    <= P_NONE;
      ackBitR  <= 1'b0;
      q        <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      rxData   <= '0;
      ackIn    <= 1'b0;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
      primDone <= 1'b0;
    end else begin
      primDone <= primEnd;
      if (active) begin
        sclOe <= sclNext;
        sdaOe <= sdaNext;
      end
      if (ctl.go) begin
        active  <= 1'b1;
        primR   <= ctl.prim;
        ackBitR <= ctl.ackBit;
        q       <= '0;
        divCnt  <= '0;
        bitCnt  <= 3'd7;
        if (ctl.prim == P_SEND) shReg <= txReg;
      end else if (active) begin
        if (qEnd) begin
          divCnt <= '0;
          q      <= q + 2'd1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        if (sampleNow) begin
          if (primR == P_RECV)  shReg <= {shReg[6:0], sdaS};
          if (primR == P_ACKIN) ackIn <= sdaS;
        end
        if (lastQ) begin
          if (primR == P_SEND) shReg <= {shReg[6:0], 1'b0};
          if (primEnd) begin
            active <= 1'b0;
            if (primR == P_RECV) rxData <= shReg;
          end else begin
            bitCnt <= bitCnt - 3'd1;
          end
        end
      end
    end
  end

  // R3
  sda_while_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) && !sclOe && !$past(sclOe) |-> (primR == P_START) || (primR == P_STOP));

  // R13
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.go |-> !active);

  // R8
  done_after_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.go |=> !primDone);

endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master import i2c_cmd_pkg::*; #(
  parameter int QTR_CYCLES  = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [3:0] cmdCode,
  input  logic       txWr,
  input  logic [7:0] txData,
  input  logic       autoTx,
  input  logic       ackOut,
  input  logic       irqClr,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [7:0] rxData,
  output logic       ackIn,
  output logic       busy,
  output logic       irqFlag
);

  step_ctl_t ctl;
  logic      primDone;

  i2c_cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdCode(cmdCode),
    .txWr(txWr), .autoTx(autoTx), .ackOut(ackOut), .irqClr(irqClr),
    .primDone(primDone), .ctl(ctl), .busy(busy), .irqFlag(irqFlag)
  );

  i2c_cmd_dp #(.QTR_CYCLES(QTR_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txWr(txWr), .txData(txData),
    .sdaIn(sdaIn), .primDone(primDone), .rxData(rxData), .ackIn(ackIn),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: tb/i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0, txWr = 1'b0, autoTx = 1'b0, ackOut = 1'b0, irqClr = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [7:0] txData = '0;
  logic sclOe, sdaOe, ackIn, busy, irqFlag;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;

  // slave model state
  logic       slvRead = 1'b0;
  logic       slvAckBit = 1'b0;
  logic [7:0] slvByte = '0;
  logic [3:0] sBit = '0;
  logic       sActive = 1'b0;
  logic       skipFall = 1'b0;
  logic [7:0] capByte = '0;
  logic       capAck = 1'b0;
  int startCnt = 0, stopCnt = 0, riseCnt = 0;
  logic slaveLow;
  logic sclLine, sdaLine;

  always #2.5 clk = ~clk;

  always_comb begin
    slaveLow = sActive && (slvRead ? ((sBit < 4'd8) && !slvByte[3'd7 - sBit[2:0]])
                                   : ((sBit == 4'd8) && !slvAckBit));
    sclLine = ~sclOe;
    sdaLine = ~(sdaOe | slaveLow);
  end

  always @(negedge sdaLine) if (sclLine) begin
    startCnt++; sActive = 1'b1; sBit = '0; skipFall = 1'b1;
  end
  always @(posedge sdaLine) if (sclLine && sActive) begin
    stopCnt++; sActive = 1'b0;
  end
  always @(posedge sclLine) begin
    riseCnt++;
    if (sActive) begin
      if (sBit < 4'd8) capByte = {capByte[6:0], sdaLine};
      else             capAck  = sdaLine;
    end
  end
  always @(negedge sclLine) if (sActive) begin
    if (skipFall) skipFall = 1'b0;
    else sBit = (sBit == 4'd8) ? 4'd0 : sBit + 4'd1;
  end

  i2c_cmd_master #(.QTR_CYCLES(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdCode(cmdCode), .txWr(txWr),
    .txData(txData), .autoTx(autoTx), .ackOut(ackOut), .irqClr(irqClr),
    .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .rxData(rxData),
    .ackIn(ackIn), .busy(busy), .irqFlag(irqFlag)
  );

  function automatic logic expAckSlot(input logic [3:0] code, input logic ao);
    case (code)
      4'b1011: return 1'b0;
      4'b1100: return 1'b1;
      default: return ao;
    endcase
  endfunction

  function automatic logic isReadCode(input logic [3:0] code);
    return (code == 4'b0100) || (code == 4'b0101) || (code == 4'b1011) || (code == 4'b1100);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitIrq();
    int n = 0;
    while (!irqFlag && n < 20000) begin @(negedge clk); n++; end
    if (!irqFlag) chk("completion timeout", 0, 1);
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] b);
    @(negedge clk); txWr = 1'b1; txData = b;
    @(negedge clk); txWr = 1'b0;
  endtask

  task automatic issue(input logic [3:0] code);
    slvRead = isReadCode(code);
    @(negedge clk); cmdWr = 1'b1; cmdCode = code;
    @(negedge clk); cmdWr = 1'b0;
  endtask

  task automatic runCmd(input logic [3:0] code);
    issue(code);
    waitIrq();
    clearIrq();
  endtask

  logic [7:0] rb;
  logic       ra;
  int         op, snap, snap2;
  logic       done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sclOe", sclOe, 0); chk("R1 sdaOe", sdaOe, 0);
    chk("R1 busy", busy, 0);   chk("R1 irqFlag", irqFlag, 0);
    chk("R1 rxData", rxData, 0); chk("R1 ackIn", ackIn, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reserved codes
    snap = riseCnt;
    issue(4'b0111);
    repeat (4) @(negedge clk);
    chk("R11 irq 0111", irqFlag, 1);
    chk("R11 no pulse", riseCnt, snap);
    chk("R11 lines", {sclOe, sdaOe}, 0);
    clearIrq();
    issue(4'b1000);
    repeat (4) @(negedge clk);
    chk("R11 irq 1000", irqFlag, 1);
    // R14 sticky flag
    repeat (40) @(negedge clk);
    chk("R14 held", irqFlag, 1);
    clearIrq();
    chk("R14 cleared", irqFlag, 0);
    chk("R11 no pulse 1000", riseCnt, snap);

    // R2 start
    snap = startCnt;
    runCmd(4'b0001);
    chk("R2 start seen", startCnt, snap + 1);
    chk("R2 busy", busy, 1);

    // R3 / R4 send and ack sample
    writeTx(8'hA5);
    runCmd(4'b0010);
    chk("R3 byte", capByte, 8'hA5);
    slvAckBit = 1'b0;
    runCmd(4'b0011);
    chk("R4 ack 0", ackIn, 0);

    // R13 command ignored while running
    writeTx(8'h3C);
    snap = stopCnt;
    issue(4'b0010);
    repeat (10) @(negedge clk);
    @(negedge clk); cmdWr = 1'b1; cmdCode = 4'b0110;
    @(negedge clk); cmdWr = 1'b0;
    waitIrq(); clearIrq();
    chk("R13 byte intact", capByte, 8'h3C);
    repeat (300) @(negedge clk);
    chk("R13 no stop", stopCnt, snap);
    chk("R13 no extra irq", irqFlag, 0);
    chk("R13 busy kept", busy, 1);
    slvAckBit = 1'b1;
    runCmd(4'b0011);
    chk("R4 ack 1", ackIn, 1);

    // R5 / R6 receive plus driven ack
    slvByte = 8'h5A; ackOut = 1'b0;
    runCmd(4'b0100);
    chk("R5 rx", rxData, 8'h5A);
    runCmd(4'b0101);
    chk("R6 ack 0", capAck, expAckSlot(4'b0101, 1'b0));
    slvByte = 8'hC3; ackOut = 1'b1;
    runCmd(4'b0100);
    chk("R5 rx 2", rxData, 8'hC3);
    runCmd(4'b0101);
    chk("R6 ack 1", capAck, expAckSlot(4'b0101, 1'b1));

    // R10 forced acks
    slvByte = 8'h81; ackOut = 1'b1;
    runCmd(4'b1011);
    chk("R10 rx 1011", rxData, 8'h81);
    chk("R10 forced 0", capAck, expAckSlot(4'b1011, ackOut));
    slvByte = 8'h7E; ackOut = 1'b0;
    runCmd(4'b1100);
    chk("R10 rx 1100", rxData, 8'h7E);
    chk("R10 forced 1", capAck, expAckSlot(4'b1100, ackOut));

    // R7 stop
    snap = stopCnt;
    runCmd(4'b0110);
    chk("R7 stop seen", stopCnt, snap + 1);
    chk("R7 busy", busy, 0);
    chk("R7 lines", {sclOe, sdaOe}, 0);

    // R8 composite start-send-ack, with a repeated start
    snap = startCnt;
    writeTx(8'hD2); slvAckBit = 1'b0;
    runCmd(4'b1001);
    chk("R8 start", startCnt, snap + 1);
    chk("R8 byte", capByte, 8'hD2);
    chk("R8 ack", ackIn, 0);
    writeTx(8'h1F); slvAckBit = 1'b1;
    runCmd(4'b1001);
    chk("R8 restart", startCnt, snap + 2);
    chk("R8 byte 2", capByte, 8'h1F);
    chk("R8 ack 2", ackIn, 1);

    // R9 composite send-ack
    writeTx(8'h66); slvAckBit = 1'b0;
    runCmd(4'b1010);
    chk("R9 byte", capByte, 8'h66);
    chk("R9 ack", ackIn, 0);

    // R12 auto-send
    slvRead = 1'b0; autoTx = 1'b1; slvAckBit = 1'b1;
    writeTx(8'hB4);
    waitIrq(); clearIrq();
    chk("R12 byte", capByte, 8'hB4);
    chk("R12 ack", ackIn, 1);
    autoTx = 1'b0;
    snap2 = riseCnt;
    writeTx(8'h00);
    repeat (300) @(negedge clk);
    chk("R12 off no irq", irqFlag, 0);
    chk("R12 off no pulse", riseCnt, snap2);
    runCmd(4'b0110);

    // random transactions
    for (int t = 0; t < 16; t++) begin
      rb = 8'($urandom); slvAckBit = 1'($urandom);
      writeTx(rb);
      runCmd(4'b1001);
      chk("R8 rand byte", capByte, rb);
      chk("R8 rand ack", ackIn, slvAckBit);
      for (int k = 0; k < 3; k++) begin
        op = $urandom_range(0, 3);
        rb = 8'($urandom); ra = 1'($urandom);
        case (op)
          0: begin
            writeTx(rb); slvAckBit = ra;
            runCmd(4'b1010);
            chk("R9 rand byte", capByte, rb); chk("R9 rand ack", ackIn, ra);
          end
          1: begin
            slvByte = rb; ackOut = ra;
            if ($urandom_range(0, 1) == 0) begin
              runCmd(4'b1011);
              chk("R10 rand ack", capAck, expAckSlot(4'b1011, ra));
            end else begin
              runCmd(4'b1100);
              chk("R10 rand nak", capAck, expAckSlot(4'b1100, ra));
            end
            chk("R10 rand rx", rxData, rb);
          end
          2: begin
            slvByte = rb; ackOut = ra;
            runCmd(4'b0100);
            chk("R5 rand rx", rxData, rb);
            runCmd(4'b0101);
            chk("R6 rand ack", capAck, expAckSlot(4'b0101, ra));
          end
          default: begin
            writeTx(rb); slvAckBit = ra;
            runCmd(4'b0010);
            chk("R3 rand byte", capByte, rb);
            runCmd(4'b0011);
            chk("R4 rand ack", ackIn, ra);
          end
        endcase
      end
      snap = stopCnt;
      runCmd(4'b0110);
      chk("R7 rand stop", stopCnt, snap + 1);
      chk("R7 rand busy", busy, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule